// File: doc/BRIEF.md
# Time-Triggered Reference Mark Unit

This block keeps the synchronisation state of a time-triggered bus controller. It takes a snapshot of a free-running local time value at every start-of-frame seen on the bus. The snapshot stays hidden until a reference frame is confirmed. When that happens, the snapshot becomes the reference mark against which the node's cycle time is measured.

The block also holds a basic-cycle counter. It works out the node's role from the configuration of the two reference mailboxes: idle, slave, or potential master.

- **Slave role:** the counter is loaded from each valid received reference frame.
- **Potential-master role:** the counter is also loaded from received reference frames. In addition, it advances on every trigger-time match, wraps at a limit chosen by a cycle-max code, and is packed into the first data byte of outgoing reference frames.
- **Gap request:** a received frame carrying the next-is-gap flag raises a sticky gap request. The host clears it by writing one.

Top module: `tt_ref_mark`

## Requirements
- R1: After reset, `refMark` is 0, `cycleCount` is 0 and `gapIrq` is 0.
- R2: `roleState` decodes as follows; any other combination gives idle (2'b00):
  - Slave (2'b01): `txReqRef`=0, `cfgRefTx`≠000, `cycleMaxCode`≠111 and `cfgRefRx`=011.
  - Master (2'b10): `txReqRef`=1, `cfgRefTx`=000, `dlcRefTx`>0, `cycleMaxCode`≠111 and `cfgRefRx`=011.
- R3: Suppose a `sofPulse` samples `localTime` at a clock edge. A later `rxRefValid`, in slave or master role, makes `refMark` equal that sampled value after the next edge. `localTime` at the moment of the commit is not used.
- R4: In master role, `txRefDone` commits the held start-of-frame value to `refMark`. In slave role, `txRefDone` leaves `refMark` unchanged.
- R5: In slave or master role, `rxRefValid` loads `cycleCount` with `rxCycleCount` one cycle later.
- R6: In master role, `trigMatch` advances `cycleCount` by one. The count returns to 0 when the old value is at or above the limit. The limit is 2^n−1 for a `cycleMaxCode` of n from 0 to 5, and 63 for code 6. In slave role, `trigMatch` has no effect.
- R7: A commit strobe with no `sofPulse` since the previous commit leaves `refMark` unchanged.
- R8: `rxRefValid` with `rxNextGap`=1, in slave or master role, sets `gapIrq`. It stays set until `gapClear`. If a set and a clear occur in the same cycle, the set wins.
- R9: `txByte0` equals `{txData0Hi, cycleCount}`: the host bits in [7:6] and the cycle count in [5:0].
- R10: In idle role, `rxRefValid`, `txRefDone` and `trigMatch` change neither `refMark`, `cycleCount` nor `gapIrq`.
- R11: When `rxRefValid` and `trigMatch` occur in the same cycle in master role, the received count is loaded and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localTime | input | 16 | Free-running local time value |
| sofPulse | input | 1 | Start-of-frame seen on the bus |
| rxRefValid | input | 1 | Valid reference frame stored in the receive reference mailbox |
| rxCycleCount | input | 6 | Cycle count carried in the received frame |
| rxNextGap | input | 1 | Next-is-gap flag of the received frame |
| txRefDone | input | 1 | Reference frame sent from the transmit reference mailbox |
| trigMatch | input | 1 | Transmit reference mailbox trigger time equals cycle time |
| txReqRef | input | 1 | Transmit request of the transmit reference mailbox |
| cfgRefTx | input | 3 | Configuration of the transmit reference mailbox |
| cfgRefRx | input | 3 | Configuration of the receive reference mailbox |
| dlcRefTx | input | 4 | Data length of the transmit reference mailbox |
| cycleMaxCode | input | 3 | Cycle-count limit code |
| txData0Hi | input | 2 | Host bits [7:6] of outgoing data byte 0 |
| gapClear | input | 1 | Write-one-to-clear for the gap request |
| refMark | output | 16 | Committed reference mark |
| cycleCount | output | 6 | Basic-cycle count |
| txByte0 | output | 8 | Packed first data byte for transmission |
| gapIrq | output | 1 | Sticky gap interrupt request |
| roleState | output | 2 | 00 idle, 01 slave, 10 master |

## Verification
Role decoding is swept through a table of mailbox settings. Each row breaks exactly one of the slave or master conditions, so every term of the decode is shown to matter on its own.

The reference mark is driven with a `localTime` at the commit that differs from the value at start-of-frame. This separates "held at SOF" from "sampled at commit". A second commit with no new SOF then separates a gated commit from an ungated one.

The cycle counter is stepped across the limits for codes 0, 2 and 6, and also from a loaded value above the limit, to tell a correct wrap from an off-by-one. Simultaneous load and step, and simultaneous gap set and clear, establish the priority rules.

// File: rtl/tt_ref_pkg.sv
package tt_ref_pkg;
  localparam int TIME_W = 16;
  localparam int CYC_W  = 6;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = 3;
  localparam int DLC_W  = 4;
  localparam logic [CFG_W-1:0] CFG_RX_REF = 3'b011;
  localparam logic [CFG_W-1:0] CFG_TX_REF = 3'b000;
  localparam logic [CFG_W-1:0] CMAX_BAD   = 3'b111;

  typedef enum logic [1:0] {
    ROLE_IDLE   = 2'b00,
    ROLE_SLAVE  = 2'b01,
    ROLE_MASTER = 2'b10
  } role_t;

  typedef struct packed {
    logic captureSof;
    logic commitMark;
    logic loadCycle;
    logic stepCycle;
  } strobe_t;
endpackage

// File: rtl/tt_ref_ctrl.sv
module tt_ref_ctrl
  import tt_ref_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sofPulse,
  input  logic             rxRefValid,
  input  logic             rxNextGap,
  input  logic             txRefDone,
  input  logic             trigMatch,
  input  logic             txReqRef,
  input  logic [CFG_W-1:0] cfgRefTx,
  input  logic [CFG_W-1:0] cfgRefRx,
  input  logic [DLC_W-1:0] dlcRefTx,
  input  logic [CFG_W-1:0] cycleMaxCode,
  input  logic             gapClear,
  output role_t            role,
  output strobe_t          strb,
  output logic             gapIrq
);
  logic slaveOk, masterOk, active, isMaster, gapSet;

  always_comb begin
    slaveOk  = !txReqRef && (cfgRefTx != CFG_TX_REF) && (cycleMaxCode != CMAX_BAD)
               && (cfgRefRx == CFG_RX_REF);
    masterOk = txReqRef && (cfgRefTx == CFG_TX_REF) && (dlcRefTx != '0)
               && (cycleMaxCode != CMAX_BAD) && (cfgRefRx == CFG_RX_REF);
    if (masterOk)     role = ROLE_MASTER;
    else if (slaveOk) role = ROLE_SLAVE;
    else              role = ROLE_IDLE;
    active   = (role != ROLE_IDLE);
    isMaster = (role == ROLE_MASTER);
    strb.captureSof = sofPulse;
    strb.commitMark = (active && rxRefValid) || (isMaster && txRefDone);
    strb.loadCycle  = active && rxRefValid;
    strb.stepCycle  = isMaster && trigMatch;
    gapSet = active && rxRefValid && rxNextGap;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         gapIrq <= 1'b0;
    else if (gapSet)   gapIrq <= 1'b1;
    else if (gapClear) gapIrq <= 1'b0;
  end

  p_role_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(role));
  p_gap_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    gapIrq && !gapClear |=> gapIrq);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (role == ROLE_IDLE) && !gapClear |=> gapIrq == $past(gapIrq));
endmodule

// File: rtl/tt_ref_dp.sv
module tt_ref_dp
  import tt_ref_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [TIME_W-1:0] localTime,
  input  logic [CYC_W-1:0]  rxCycleCount,
  input  logic [CFG_W-1:0]  cycleMaxCode,
  output logic [TIME_W-1:0] refMark,
  output logic [CYC_W-1:0]  cycleCount
);
  logic [TIME_W-1:0] sofHold;
  logic              holdValid;
  logic [CYC_W-1:0]  maxVal;
  logic              doCommit;

  always_comb begin
    if (int'(cycleMaxCode) >= CYC_W) maxVal = '1;
    else                             maxVal = ~({CYC_W{1'b1}} << cycleMaxCode);
    doCommit = strb.commitMark && holdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sofHold   <= '0;
      holdValid <= 1'b0;
      refMark   <= '0;
    end else begin
      if (strb.captureSof) sofHold <= localTime;
      if (doCommit)        refMark <= sofHold;
      if (strb.captureSof) holdValid <= 1'b1;
      else if (doCommit)   holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    cycleCount <= '0;
    else if (strb.loadCycle)      cycleCount <= rxCycleCount;
    else if (strb.stepCycle) begin
      if (cycleCount >= maxVal)   cycleCount <= '0;
      else                        cycleCount <= cycleCount + 1'b1;
    end
  end

  p_mark_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commitMark && holdValid) |=> $stable(refMark));
  p_cycle_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepCycle && !strb.loadCycle && (cycleCount >= maxVal) |=> cycleCount == '0);
  p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepCycle && !strb.loadCycle && (cycleCount < maxVal)
    |=> cycleCount == $past(cycleCount) + 1'b1);
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCycle |=> cycleCount == $past(rxCycleCount));
endmodule

// File: rtl/tt_ref_mark.sv
module tt_ref_mark
  import tt_ref_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] localTime,
  input  logic              sofPulse,
  input  logic              rxRefValid,
  input  logic [CYC_W-1:0]  rxCycleCount,
  input  logic              rxNextGap,
  input  logic              txRefDone,
  input  logic              trigMatch,
  input  logic              txReqRef,
  input  logic [CFG_W-1:0]  cfgRefTx,
  input  logic [CFG_W-1:0]  cfgRefRx,
  input  logic [DLC_W-1:0]  dlcRefTx,
  input  logic [CFG_W-1:0]  cycleMaxCode,
  input  logic [BYTE_W-CYC_W-1:0] txData0Hi,
  input  logic              gapClear,
  output logic [TIME_W-1:0] refMark,
  output logic [CYC_W-1:0]  cycleCount,
  output logic [BYTE_W-1:0] txByte0,
  output logic              gapIrq,
  output logic [1:0]        roleState
);
  role_t   role;
  strobe_t strb;

  tt_ref_ctrl u_ctrl (
    .clk, .rstN, .sofPulse, .rxRefValid, .rxNextGap, .txRefDone, .trigMatch,
    .txReqRef, .cfgRefTx, .cfgRefRx, .dlcRefTx, .cycleMaxCode, .gapClear,
    .role, .strb, .gapIrq
  );

  tt_ref_dp u_dp (
    .clk, .rstN, .strb, .localTime, .rxCycleCount, .cycleMaxCode,
    .refMark, .cycleCount
  );

  assign txByte0   = {txData0Hi, cycleCount};
  assign roleState = role;

  p_slave_no_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (role == ROLE_SLAVE) && !rxRefValid |=> $stable(cycleCount));
  p_slave_tx_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (role == ROLE_SLAVE) && !rxRefValid |=> $stable(refMark));
endmodule

// File: tb/tt_ref_mark_bench.sv
module tt_ref_mark_bench;
  logic clk = 0, rstN = 0;
  logic [15:0] localTime = 0;
  logic sofPulse = 0, rxRefValid = 0, rxNextGap = 0, txRefDone = 0, trigMatch = 0;
  logic [5:0] rxCycleCount = 0;
  logic txReqRef = 0, gapClear = 0;
  logic [2:0] cfgRefTx = 0, cfgRefRx = 0, cycleMaxCode = 0;
  logic [3:0] dlcRefTx = 0;
  logic [1:0] txData0Hi = 0;
  logic [15:0] refMark;
  logic [5:0] cycleCount;
  logic [7:0] txByte0;
  logic gapIrq;
  logic [1:0] roleState;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  tt_ref_mark u_tt_ref_mark (.*);

  // {txReq, cfgTx[3], cfgRx[3], dlc[4], cmax[3], expRole[2]}
  localparam logic [15:0] ROLE_VEC [8] = '{
    {1'b0, 3'b001, 3'b011, 4'd0, 3'd2, 2'b01},
    {1'b1, 3'b000, 3'b011, 4'd8, 3'd2, 2'b10},
    {1'b1, 3'b000, 3'b011, 4'd0, 3'd2, 2'b00},
    {1'b0, 3'b000, 3'b011, 4'd0, 3'd2, 2'b00},
    {1'b0, 3'b001, 3'b011, 4'd0, 3'd7, 2'b00},
    {1'b1, 3'b000, 3'b011, 4'd1, 3'd7, 2'b00},
    {1'b0, 3'b001, 3'b010, 4'd0, 3'd2, 2'b00},
    {1'b1, 3'b001, 3'b011, 4'd8, 3'd2, 2'b00}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setSlave(logic [2:0] cmax);
    txReqRef = 0; cfgRefTx = 3'b001; cfgRefRx = 3'b011; dlcRefTx = 0; cycleMaxCode = cmax;
  endtask

  task automatic setMaster(logic [2:0] cmax);
    txReqRef = 1; cfgRefTx = 3'b000; cfgRefRx = 3'b011; dlcRefTx = 8; cycleMaxCode = cmax;
  endtask

  // strobes applied at a negedge, cleared at the next; outputs checked there
  task automatic sof(logic [15:0] t);
    localTime = t; sofPulse = 1; @(negedge clk); sofPulse = 0;
  endtask

  task automatic rx(logic [5:0] cnt, logic gap);
    rxCycleCount = cnt; rxNextGap = gap; rxRefValid = 1;
    @(negedge clk); rxRefValid = 0; rxNextGap = 0;
  endtask

  task automatic step;
    trigMatch = 1; @(negedge clk); trigMatch = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 refMark", 32'(refMark), 0);
    check("R1 cycleCount", 32'(cycleCount), 0);
    check("R1 gapIrq", 32'(gapIrq), 0);

    for (int i = 0; i < 8; i++) begin
      {txReqRef, cfgRefTx, cfgRefRx, dlcRefTx, cycleMaxCode} = ROLE_VEC[i][15:2];
      #1;
      check($sformatf("R2 role row %0d", i), 32'(roleState), 32'(ROLE_VEC[i][1:0]));
    end

    // R3/R5: held SOF value, not commit-time value
    setSlave(3'd2);
    @(negedge clk);
    sof(16'h1234);
    localTime = 16'h5555;
    rx(6'd5, 0);
    check("R3 refMark from SOF", 32'(refMark), 32'h1234);
    check("R5 cycle loaded", 32'(cycleCount), 5);

    // R7: commit without new SOF
    rx(6'd9, 0);
    check("R7 refMark unchanged", 32'(refMark), 32'h1234);
    check("R5 cycle reloaded", 32'(cycleCount), 9);

    // R4: slave ignores txRefDone, master commits
    sof(16'h2222);
    txRefDone = 1; @(negedge clk); txRefDone = 0;
    check("R4 slave tx ignored", 32'(refMark), 32'h1234);
    setMaster(3'd2);
    txRefDone = 1; @(negedge clk); txRefDone = 0;
    check("R4 master tx commit", 32'(refMark), 32'h2222);

    // R6: wrap behaviour
    step;  // loaded 9 above limit 3 -> 0
    check("R6 wrap from above limit", 32'(cycleCount), 0);
    rx(6'd2, 0);
    step;
    check("R6 step 2->3", 32'(cycleCount), 3);
    step;
    check("R6 wrap 3->0", 32'(cycleCount), 0);
    setMaster(3'd6);
    rx(6'd62, 0);
    step;
    check("R6 code6 62->63", 32'(cycleCount), 63);
    step;
    check("R6 code6 wrap", 32'(cycleCount), 0);
    setMaster(3'd0);
    step;
    check("R6 code0 stays 0", 32'(cycleCount), 0);

    // R11: load beats step
    setMaster(3'd5);
    trigMatch = 1; rx(6'd7, 0); trigMatch = 0;
    check("R11 load wins", 32'(cycleCount), 7);

    // R6: slave ignores trigMatch
    setSlave(3'd5);
    step;
    check("R6 slave step ignored", 32'(cycleCount), 7);

    // R9 packing
    txData0Hi = 2'b10; #1;
    check("R9 txByte0", 32'(txByte0), 32'h87);

    // R8 gap
    rx(6'd7, 1);
    check("R8 gap set", 32'(gapIrq), 1);
    @(negedge clk);
    check("R8 gap held", 32'(gapIrq), 1);
    gapClear = 1; @(negedge clk); gapClear = 0;
    check("R8 gap cleared", 32'(gapIrq), 0);
    gapClear = 1; rx(6'd7, 1); gapClear = 0;
    check("R8 set beats clear", 32'(gapIrq), 1);

    // R10 idle ignores strobes
    cfgRefRx = 3'b000;
    sof(16'h7777);
    trigMatch = 1; txRefDone = 1; rx(6'd20, 0); trigMatch = 0; txRefDone = 0;
    check("R10 idle refMark", 32'(refMark), 32'h2222);
    check("R10 idle cycle", 32'(cycleCount), 7);
    check("R10 idle gap", 32'(gapIrq), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule